// File: doc/BRIEF.md
# Streaming Block Program Controller

This block is the write sequencer in front of a simulated flash array. A host programs a whole block by starting the operation once with a start address and then pushing data words with no address of their own. The controller pulses each word into the array, moves its word pointer forward by itself, and keeps a private copy of every word it accepts. When the host writes a word whose address falls outside the target block, the controller compares the array against that copy on its own, then passes through a one-cycle exit phase and goes back to idle.

The host learns everything through an 8-bit status value that it polls: ready, the current phase, and sticky error flags. A start request is refused when the target block is locked or the high-voltage supply is not good. A suspend request has no effect. Array reads through the read port are refused while any phase other than idle is active.

Top module: `stream_prog_ctrl`

## Requirements
- R1: After reset, status reads 0x80 (bit 7 ready, phase bits 6:5 = 00 idle, all error bits 0), fail_off reads 0 and every array word reads 0xFFFF.
- R2: A start command (host_op 00) in idle that targets a block whose blk_lock bit is set sets status bit 1 and leaves the phase at 00.
- R3: A start command in idle while hv_good is low sets status bit 3 and leaves the phase at 00. With both faults present, bits 1 and 3 are both set.
- R4: An accepted start command moves to the program phase (bits 6:5 = 01) with ready set, so status reads 0xA0 on the next cycle. The start offset is taken from the low BLK_W address bits.
- R5: Each accepted data word (host_op 01, address inside the target block) clears ready for exactly PULSE_CYC cycles, starting the cycle after acceptance. It is then ANDed into the array at start offset plus the number of words already programmed. The offset bits of the data address are ignored.
- R6: A data word that arrives while ready is low, or after the last word of the block has been taken, sets status bit 4 and is dropped.
- R7: A data word whose block field differs from the target block, arriving while ready is set in the program phase, moves to verify (bits 6:5 = 10, ready low). Verify takes one cycle per programmed word plus one, followed by one exit cycle (bits 6:5 = 11), and then the phase returns to idle.
- R8: Verify compares every programmed word with the captured copy. A mismatch sets sticky status bit 0, and fail_off holds the offset of the first mismatch until a clear.
- R9: A suspend command (host_op 10) changes neither the status nor the progress of an operation.
- R10: A read request is answered one cycle later on rd_data with rd_ok set while idle. rd_ok is low for a request made in any other phase.
- R11: A clear command (host_op 11) zeroes status bits 4, 3, 1 and 0 and fail_off, and leaves the ready and phase bits as they are.
- R12: Only the target block is written. The exit word and any data word received in idle are never written to the array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host command strobe |
| host_op | input | 2 | 00 start, 01 data, 10 suspend, 11 clear status |
| host_addr | input | ADDR_W | Word address (block field in the upper ADDR_W-BLK_W bits) |
| host_data | input | DATA_W | Program data |
| blk_lock | input | 2**(ADDR_W-BLK_W) | Per-block lock bits |
| hv_good | input | 1 | High-voltage supply within range |
| status | output | 8 | Status value polled by the host |
| fail_off | output | BLK_W | Offset of the first verify mismatch |
| rd_en | input | 1 | Array read request |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Read data, valid one cycle after the request |
| rd_ok | output | 1 | Read accepted (idle only) |

## Verification
The hardest state to reach is a verify mismatch. The array only clears bits, and the controller verifies exactly what it just wrote, so a single clean run never fails. The bench therefore programs a block region first and later streams all-ones words over the same offsets. The AND model keeps the earlier zeros, so the compare fails at a known offset, and a second failing word then shows that the first offset stays recorded. Dropped words are reached by sending a second data word inside the pulse window of the first, and by streaming one word past the end of a block started at its last offset.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'b00,
        PH_PROG   = 2'b01,
        PH_VERIFY = 2'b10,
        PH_EXIT   = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        OP_START   = 2'b00,
        OP_DATA    = 2'b01,
        OP_SUSPEND = 2'b10,
        OP_CLEAR   = 2'b11
    } host_op_e;

    typedef struct packed {
        logic perr;     // dropped data word
        logic hverr;    // supply not good at start
        logic lockerr;  // target block locked at start
        logic verr;     // verify mismatch
    } err_flags_t;

    function automatic logic [7:0] pack_status(logic rdy, phase_e ph, err_flags_t e);
        logic [7:0] s;
        s      = '0;
        s[7]   = rdy;
        s[6:5] = ph;
        s[4]   = e.perr;
        s[3]   = e.hverr;
        s[1]   = e.lockerr;
        s[0]   = e.verr;
        return s;
    endfunction

endpackage

// File: rtl/spc_pulse_timer.sv
module spc_pulse_timer #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
endmodule

// File: rtl/spc_array_model.sv
module spc_array_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    // programming can only clear bits; reset stands in for an erased array
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (pgm_en) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/spc_shadow_buf.sv
module spc_shadow_buf #(
    parameter int BLK_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [BLK_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BLK_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    localparam int WORDS = 1 << BLK_W;

    logic [DATA_W-1:0] buf_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) buf_q[wr_off] <= wr_data;
    end

    assign rd_data = buf_q[rd_off];
endmodule

// File: rtl/stream_prog_ctrl.sv
module stream_prog_ctrl
    import spc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BLK_W     = 4,
    parameter int DATA_W    = 16,
    parameter int PULSE_CYC = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              host_valid,
    input  logic [1:0]                        host_op,
    input  logic [ADDR_W-1:0]                 host_addr,
    input  logic [DATA_W-1:0]                 host_data,
    input  logic [(1 << (ADDR_W-BLK_W))-1:0]  blk_lock,
    input  logic                              hv_good,
    output logic [7:0]                        status,
    output logic [BLK_W-1:0]                  fail_off,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic                              rd_ok
);
    localparam int BLK_WORDS = 1 << BLK_W;
    localparam int BSEL_W    = ADDR_W - BLK_W;
    localparam int CNT_W     = BLK_W + 1;

    phase_e             phase;
    err_flags_t         err;
    logic [BSEL_W-1:0]  tgt_blk;
    logic [BLK_W-1:0]   start_off;
    logic [CNT_W-1:0]   count;
    logic [CNT_W-1:0]   vidx;
    logic [DATA_W-1:0]  wlatch;

    host_op_e           op;
    logic [BSEL_W-1:0]  cmd_blk;
    logic               in_blk, room, busy, pulse_done;
    logic               accept, pgm_fault, go_verify, v_active, mismatch;
    logic [BLK_W-1:0]   wptr, vptr;
    logic [ADDR_W-1:0]  arr_rd_addr;
    logic [DATA_W-1:0]  arr_q, shadow_q;

    assign op        = host_op_e'(host_op);
    assign cmd_blk   = host_addr[ADDR_W-1:BLK_W];
    assign in_blk    = (cmd_blk == tgt_blk);
    assign room      = ({1'b0, start_off} + count) < CNT_W'(BLK_WORDS);
    assign wptr      = start_off + count[BLK_W-1:0];
    assign vptr      = start_off + vidx[BLK_W-1:0];

    assign accept    = (phase == PH_PROG) && host_valid && (op == OP_DATA) && !busy && in_blk && room;
    assign pgm_fault = (phase == PH_PROG) && host_valid && (op == OP_DATA) && (busy || (in_blk && !room));
    assign go_verify = (phase == PH_PROG) && host_valid && (op == OP_DATA) && !busy && !in_blk;
    assign v_active  = (phase == PH_VERIFY) && (vidx != count);
    assign mismatch  = v_active && (arr_q != shadow_q);

    assign arr_rd_addr = (phase == PH_VERIFY) ? {tgt_blk, vptr} : rd_addr;

    spc_pulse_timer #(.CYC(PULSE_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .busy  (busy),
        .done  (pulse_done)
    );

    spc_array_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .pgm_en   (pulse_done),
        .pgm_addr ({tgt_blk, wptr}),
        .pgm_data (wlatch),
        .rd_addr  (arr_rd_addr),
        .rd_data  (arr_q)
    );

    spc_shadow_buf #(.BLK_W(BLK_W), .DATA_W(DATA_W)) u_shadow (
        .clk     (clk),
        .wr_en   (accept),
        .wr_off  (wptr),
        .wr_data (host_data),
        .rd_off  (vptr),
        .rd_data (shadow_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            err       <= '0;
            tgt_blk   <= '0;
            start_off <= '0;
            count     <= '0;
            vidx      <= '0;
            wlatch    <= '0;
            fail_off  <= '0;
            rd_ok     <= 1'b0;
            rd_data   <= '0;
        end else begin
            rd_ok <= rd_en && (phase == PH_IDLE);
            if (rd_en) rd_data <= arr_q;

            unique case (phase)
                PH_IDLE: begin
                    if (host_valid && op == OP_START) begin
                        if (blk_lock[cmd_blk]) err.lockerr <= 1'b1;
                        if (!hv_good)          err.hverr   <= 1'b1;
                        if (!blk_lock[cmd_blk] && hv_good) begin
                            phase     <= PH_PROG;
                            tgt_blk   <= cmd_blk;
                            start_off <= host_addr[BLK_W-1:0];
                            count     <= '0;
                            vidx      <= '0;
                        end
                    end
                end
                PH_PROG: begin
                    if (accept)     wlatch   <= host_data;
                    if (pulse_done) count    <= count + CNT_W'(1);
                    if (pgm_fault)  err.perr <= 1'b1;
                    if (go_verify)  phase    <= PH_VERIFY;
                end
                PH_VERIFY: begin
                    if (v_active) begin
                        vidx <= vidx + CNT_W'(1);
                        if (mismatch && !err.verr) begin
                            err.verr <= 1'b1;
                            fail_off <= vptr;
                        end
                    end else begin
                        phase <= PH_EXIT;
                    end
                end
                PH_EXIT: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase

            // clear wins over any flag set in the same cycle
            if (host_valid && op == OP_CLEAR) begin
                err      <= '0;
                fail_off <= '0;
            end
        end
    end

    assign status = pack_status((phase == PH_IDLE) || ((phase == PH_PROG) && !busy), phase, err);
endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int ADDR_W = 8,
    parameter int BLK_W  = 4
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              host_valid,
    input logic [1:0]                        host_op,
    input logic [ADDR_W-1:0]                 host_addr,
    input logic [(1 << (ADDR_W-BLK_W))-1:0]  blk_lock,
    input logic                              hv_good,
    input logic [7:0]                        status,
    input logic                              rd_en,
    input logic                              rd_ok
);
    logic in_idle, in_prog, is_start, is_data, is_susp, is_clr;
    assign in_idle  = (status[6:5] == 2'b00);
    assign in_prog  = (status[6:5] == 2'b01);
    assign is_start = host_valid && (host_op == 2'b00);
    assign is_data  = host_valid && (host_op == 2'b01);
    assign is_susp  = host_valid && (host_op == 2'b10);
    assign is_clr   = host_valid && (host_op == 2'b11);

    // R2
    p_lock_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        (in_idle && is_start && blk_lock[host_addr[ADDR_W-1:BLK_W]]) |=> (status[1] && status[6:5] == 2'b00));

    // R3
    p_hv_refuse_r3: assert property (@(posedge clk) disable iff (rst)
        (in_idle && is_start && !hv_good) |=> (status[3] && status[6:5] == 2'b00));

    // R5: an accepted or faulted data word never leaves ready high in program phase without an error
    p_pulse_start_r5: assert property (@(posedge clk) disable iff (rst)
        (in_prog && status[7] && is_data) |=> (!status[7] || status[6:5] == 2'b10 || status[4]));

    // R7
    p_exit_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (status[6:5] == 2'b11) |=> (status[6:5] == 2'b00));

    p_idle_leaves_to_prog_r7: assert property (@(posedge clk) disable iff (rst)
        in_idle |=> (status[6:5] == 2'b00 || status[6:5] == 2'b01));

    // R8
    p_verr_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !is_clr) |=> status[0]);

    // R9
    p_suspend_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (in_idle && is_susp) |=> $stable(status));

    // R10
    p_read_blocked_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !in_idle) |=> !rd_ok);

    // R11
    p_clear_r11: assert property (@(posedge clk) disable iff (rst)
        is_clr |=> (status[4:3] == 2'b00 && status[1:0] == 2'b00));
endmodule

bind stream_prog_ctrl spc_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_valid (host_valid),
    .host_op    (host_op),
    .host_addr  (host_addr),
    .blk_lock   (blk_lock),
    .hv_good    (hv_good),
    .status     (status),
    .rd_en      (rd_en),
    .rd_ok      (rd_ok)
);

// File: tb/stream_prog_ctrl_tb.sv
`timescale 1ns/1ps
module stream_prog_ctrl_tb;
    localparam int ADDR_W = 8;
    localparam int BLK_W  = 4;
    localparam int DATA_W = 16;
    localparam int PULSE  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              host_valid = 1'b0;
    logic [1:0]        host_op = 2'b00;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_data = '0;
    logic [15:0]       blk_lock = '0;
    logic              hv_good = 1'b1;
    logic [7:0]        status;
    logic [BLK_W-1:0]  fail_off;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_ok;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 0;

    always #2 clk = ~clk;

    stream_prog_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W), .PULSE_CYC(PULSE)) u_dut (
        .clk(clk), .rst(rst), .host_valid(host_valid), .host_op(host_op),
        .host_addr(host_addr), .host_data(host_data), .blk_lock(blk_lock),
        .hv_good(hv_good), .status(status), .fail_off(fail_off),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ok(rd_ok)
    );

    typedef struct packed {
        logic [3:0]  blk;
        logic [3:0]  off;
        logic [4:0]  n;
        logic [15:0] seed;
    } run_t;

    localparam run_t RUNS [5] = '{
        '{blk: 4'd2, off: 4'd0,  n: 5'd16, seed: 16'hA5A5},
        '{blk: 4'd3, off: 4'd5,  n: 5'd4,  seed: 16'h1234},
        '{blk: 4'd4, off: 4'd15, n: 5'd1,  seed: 16'h0F0F},
        '{blk: 4'd5, off: 4'd7,  n: 5'd0,  seed: 16'h5555},
        '{blk: 4'd6, off: 4'd3,  n: 5'd6,  seed: 16'hC3C3}
    };

    function automatic logic [15:0] pat(logic [15:0] seed, int i);
        return seed ^ (16'(i) * 16'h1111);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [1:0] op, input logic [7:0] addr, input logic [15:0] data);
        @(negedge clk);
        host_valid = 1'b1; host_op = op; host_addr = addr; host_data = data;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 200 && !status[7]; k++) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] addr, output logic ok, output logic [15:0] data);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = addr;
        @(negedge clk);
        rd_en = 1'b0;
        ok = rd_ok; data = rd_data;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] addr, input logic [15:0] exp);
        logic ok; logic [15:0] d;
        rd(addr, ok, d);
        chk(tag, {15'd0, ok, d}, {15'd0, 1'b1, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic ok; logic [15:0] d; int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", {24'd0, status}, 32'h80);
        chk("R1 fail_off", {28'd0, fail_off}, 32'h0);
        rd_chk("R1 erased word", 8'h00, 16'hFFFF);

        // table of streaming runs
        foreach (RUNS[r]) begin
            cmd(2'b00, {RUNS[r].blk, RUNS[r].off}, 16'h0);
            chk("R4 start accepted", {24'd0, status}, 32'hA0);
            for (int i = 0; i < int'(RUNS[r].n); i++) begin
                cmd(2'b01, {RUNS[r].blk, 4'(i * 7)}, pat(RUNS[r].seed, i));
                wait_ready();
            end
            cmd(2'b01, {RUNS[r].blk + 4'd1, 4'h0}, 16'h0000);
            chk("R7 verify entered", {24'd0, status}, 32'h40);
            wait_ready();
            chk("R7 back to idle clean", {24'd0, status}, 32'h80);
            for (int i = 0; i < int'(RUNS[r].n); i++)
                rd_chk("R5 word programmed", {RUNS[r].blk, RUNS[r].off + 4'(i)}, pat(RUNS[r].seed, i));
            if (RUNS[r].off != 4'd0)
                rd_chk("R12 word before start", {RUNS[r].blk, RUNS[r].off - 4'd1}, 16'hFFFF);
            rd_chk("R12 exit word not written", {RUNS[r].blk + 4'd1, 4'h0}, 16'hFFFF);
        end

        // R2 / R3 refusals, R11 clear
        blk_lock[9] = 1'b1;
        cmd(2'b00, 8'h90, 16'h0);
        chk("R2 locked start", {24'd0, status}, 32'h82);
        cmd(2'b11, 8'h00, 16'h0);
        chk("R11 clear", {24'd0, status}, 32'h80);
        hv_good = 1'b0;
        cmd(2'b00, 8'hA0, 16'h0);
        chk("R3 supply start", {24'd0, status}, 32'h88);
        cmd(2'b00, 8'h90, 16'h0);
        chk("R3 both faults", {24'd0, status}, 32'h8A);
        hv_good = 1'b1; blk_lock[9] = 1'b0;
        cmd(2'b11, 8'h00, 16'h0);
        chk("R11 clear both", {24'd0, status}, 32'h80);

        // R9 suspend in idle, R12 data in idle ignored
        cmd(2'b10, 8'hD0, 16'h0);
        chk("R9 suspend idle", {24'd0, status}, 32'h80);
        cmd(2'b01, 8'hD0, 16'h0000);
        chk("R12 idle data status", {24'd0, status}, 32'h80);
        rd_chk("R12 idle data not written", 8'hD0, 16'hFFFF);

        // R5 pulse length, R6 busy drop, R9 suspend while busy, R10 blocked read
        cmd(2'b00, 8'hA0, 16'h0);
        cmd(2'b01, 8'hA0, 16'h1111);
        n = 0;
        while (!status[7] && n < 100) begin n++; @(negedge clk); end
        chk("R5 ready low cycles", n, PULSE);
        cmd(2'b01, 8'hA0, 16'h2222);
        cmd(2'b10, 8'hA0, 16'h0);
        chk("R9 suspend keeps busy", {24'd0, status}, 32'h20);
        cmd(2'b01, 8'hA0, 16'h3333);
        chk("R6 busy drop flag", {31'd0, status[4]}, 32'h1);
        rd(8'h00, ok, d);
        chk("R10 read blocked", {31'd0, ok}, 32'h0);
        wait_ready();
        chk("R6 prog status", {24'd0, status}, 32'hB0);
        cmd(2'b01, 8'hB0, 16'h0);
        wait_ready();
        chk("R6 idle with flag", {24'd0, status}, 32'h90);
        rd_chk("R5 word0", 8'hA0, 16'h1111);
        rd_chk("R9 word1 after suspend", 8'hA1, 16'h2222);
        rd_chk("R6 dropped word", 8'hA2, 16'hFFFF);
        cmd(2'b11, 8'h00, 16'h0);

        // R6 block end overflow
        cmd(2'b00, 8'hBF, 16'h0);
        cmd(2'b01, 8'hB0, 16'h7E7E);
        wait_ready();
        cmd(2'b01, 8'hB0, 16'h0000);
        chk("R6 overflow flag", {24'd0, status}, 32'hB0);
        cmd(2'b01, 8'hC0, 16'h0);
        wait_ready();
        rd_chk("R6 last word", 8'hBF, 16'h7E7E);
        rd_chk("R6 no wrap write", 8'hB0, 16'hFFFF);
        cmd(2'b11, 8'h00, 16'h0);
        chk("R11 clear perr", {24'd0, status}, 32'h80);

        // R8 verify mismatch: restream all-ones over block 3 offset 5
        cmd(2'b00, 8'h35, 16'h0);
        cmd(2'b01, 8'h30, 16'hFFFF);
        wait_ready();
        cmd(2'b01, 8'h40, 16'h0);
        wait_ready();
        chk("R8 verify error", {24'd0, status}, 32'h81);
        chk("R8 fail offset", {28'd0, fail_off}, 32'h5);
        cmd(2'b00, 8'h36, 16'h0);
        cmd(2'b01, 8'h30, 16'hFFFF);
        wait_ready();
        cmd(2'b01, 8'h40, 16'h0);
        wait_ready();
        chk("R8 sticky flag", {24'd0, status}, 32'h81);
        chk("R8 first offset kept", {28'd0, fail_off}, 32'h5);
        cmd(2'b11, 8'h00, 16'h0);
        chk("R11 clear verr", {24'd0, status}, 32'h80);
        chk("R11 clear offset", {28'd0, fail_off}, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule